// File: doc/BRIEF.md
# Ones' Complement Accumulator Arithmetic Unit

This block performs the add-type arithmetic of an 18-bit accumulator machine that stores signed values in ones' complement form. A negative value is the bitwise inverse of its magnitude. Each request carries the current accumulator, a memory operand and a 2-bit operation code. The block returns the new accumulator word. It also returns a write-back word and a write-back flag for the increment forms, a skip request for the increment-and-skip form, and a sticky overflow flag.

A caller pulses `start` for one cycle with the operands valid. One clock later `done` pulses and the outputs hold the new values. Addition folds the carry out of the top bit back into the low bit, then turns an all-ones (negative zero) sum into zero. Subtraction inverts the accumulator, adds with end-around carry, tests overflow, and inverts the sum again. It skips the negative-zero step, so subtracting positive zero from negative zero leaves all ones. The overflow flag only ever gets set by arithmetic. It is cleared only by reset or by the `ovf_clr` input.

Top module: `oc_arith_unit`

## Requirements
- R1: With op code 0 (add), `result` is acc + opnd, with the carry out of bit 17 added back into bit 0. An all-ones sum is then replaced by zero, so add never returns all ones.
- R2: With op code 1 (subtract), `result` is the inverse of ((inverse of acc) + opnd, with end-around carry). No negative-zero cleanup is applied, so all-ones minus zero gives all ones (0x3FFFF).
- R3: Overflow is detected when the two adder inputs share a sign bit (bit 17) and the sum's sign bit differs from it. For add the inputs are acc and opnd. For subtract they are the inverted acc and opnd.
- R4: `ovf` is sticky. Once set, it stays at 1 through later operations without overflow. Op codes 2 and 3 never change it.
- R5: `ovf_clr` high at a clock edge clears `ovf` at that edge. This takes priority over an overflow detected in the same cycle.
- R6: With op code 2 (increment) or 3, the result is opnd + 1. When that sum is 0x3FFFF or larger, one more is added and the value is truncated to 18 bits, so 0x3FFFE gives 0 and 0x3FFFF gives 1. `wb_en` is 1 with `done` for op codes 2 and 3 only, and `wb_data` then equals `result`.
- R7: With op code 3 (increment and skip), `skip_req` is 1 when bit 17 of the incremented result is 0. `skip_req` is 0 for every other op code.
- R8: `done` is high for exactly one cycle, the cycle after `start` was sampled high. `result` changes only in that cycle and otherwise holds its value.
- R9: After reset `result`, `wb_data`, `ovf`, `done`, `skip_req` and `wb_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| op | input | 2 | 0 add, 1 subtract, 2 increment, 3 increment and skip |
| acc_in | input | 18 | Accumulator operand |
| opnd_in | input | 18 | Memory operand |
| ovf_clr | input | 1 | Synchronous clear of the overflow flag |
| result | output | 18 | New accumulator value |
| wb_data | output | 18 | Data to write back to memory for increment forms |
| wb_en | output | 1 | Write-back request, valid with done |
| skip_req | output | 1 | Skip request, valid with done |
| ovf | output | 1 | Sticky overflow flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The vector table covers several classes of operand pair:
- Same-sign operands without carry, which check the plain sum.
- Mixed-sign pairs that wrap past bit 17, which show whether the end-around carry is applied.
- Pairs whose sum is negative zero. The same pair gives zero under add and all ones under subtract, which exposes any cleanup applied to the wrong operation.
- Operands at the positive limit, which show overflow under both add and subtract.

Increment operands just below, at and above the all-ones boundary separate the double increment from a plain one. Their sign bits decide the skip. Directed sequences cover three more cases: overflow persisting across clean operations, the clear taking priority over a simultaneous overflow, and the single-cycle `done` pulse with `result` holding afterwards.

// File: rtl/oc_arith_pkg.sv
package oc_arith_pkg;

    localparam int unsigned WORD_W = 18;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_INC = 2'd2,
        OP_ISK = 2'd3
    } arith_op_e;

endpackage

// File: rtl/oc_eac_adder.sv
// Binary add of two words with the carry out of the top bit folded back in.
module oc_eac_adder #(
    parameter int unsigned W = 18
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        // the top-bit carry re-enters at bit 0; this second add cannot carry again
        sum = raw[W] ? (raw[W-1:0] + ONE) : raw[W-1:0];
    end
endmodule

// File: rtl/oc_incr.sv
// Increment that steps over the all-ones code.
module oc_incr #(
    parameter int unsigned W = 18
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] inc
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};
    localparam logic [W-1:0] NEAR = ALL1 - {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] TWO  = ONE + ONE;

    logic skip_code;

    always_comb begin
        // val+1 reaching all ones or beyond means one extra step
        skip_code = (val >= NEAR);
        inc       = val + (skip_code ? TWO : ONE);
    end
endmodule

// File: rtl/oc_op_unit.sv
// Combinational datapath: one shared end-around adder for add and subtract,
// a separate incrementer for the two index forms.
module oc_op_unit
    import oc_arith_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  arith_op_e    op,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] res,
    output logic         ov_hit,
    output logic         skip,
    output logic         wb
);
    localparam int unsigned SB   = W - 1;
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic [W-1:0] add_a;
    logic [W-1:0] add_sum;
    logic [W-1:0] inc_val;

    always_comb begin
        add_a = (op == OP_SUB) ? ~acc : acc;
    end

    oc_eac_adder #(.W(W)) adder_i (
        .a   (add_a),
        .b   (opnd),
        .sum (add_sum)
    );

    oc_incr #(.W(W)) incr_i (
        .val (opnd),
        .inc (inc_val)
    );

    always_comb begin
        res    = '0;
        ov_hit = 1'b0;
        skip   = 1'b0;
        wb     = 1'b0;
        unique case (op)
            OP_ADD: begin
                ov_hit = (add_a[SB] == opnd[SB]) && (add_sum[SB] != add_a[SB]);
                res    = (add_sum == ALL1) ? '0 : add_sum;
            end
            OP_SUB: begin
                ov_hit = (add_a[SB] == opnd[SB]) && (add_sum[SB] != add_a[SB]);
                res    = ~add_sum;
            end
            OP_INC: begin
                res = inc_val;
                wb  = 1'b1;
            end
            OP_ISK: begin
                res  = inc_val;
                wb   = 1'b1;
                skip = ~inc_val[SB];
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/oc_arith_unit.sv
module oc_arith_unit
    import oc_arith_pkg::*;
#(
    parameter int unsigned W = oc_arith_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] opnd_in,
    input  logic         ovf_clr,
    output logic [W-1:0] result,
    output logic [W-1:0] wb_data,
    output logic         wb_en,
    output logic         skip_req,
    output logic         ovf,
    output logic         done
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         wb;
        logic         skip;
        logic         ovf;
        logic         done;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic [W-1:0] u_res;
    logic         u_ov;
    logic         u_skip;
    logic         u_wb;

    oc_op_unit #(.W(W)) op_i (
        .op     (arith_op_e'(op)),
        .acc    (acc_in),
        .opnd   (opnd_in),
        .res    (u_res),
        .ov_hit (u_ov),
        .skip   (u_skip),
        .wb     (u_wb)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        st_d.skip = start && u_skip;
        st_d.wb   = start && u_wb;
        if (start) begin
            st_d.res = u_res;
        end
        if (ovf_clr) begin
            st_d.ovf = 1'b0;
        end else if (start && u_ov) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result   = st_q.res;
    assign wb_data  = st_q.res;
    assign wb_en    = st_q.wb;
    assign skip_req = st_q.skip;
    assign ovf      = st_q.ovf;
    assign done     = st_q.done;
endmodule

// File: rtl/oc_arith_unit_chk.sv
module oc_arith_unit_chk #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   op,
    input logic         ovf_clr,
    input logic [W-1:0] result,
    input logic         wb_en,
    input logic         skip_req,
    input logic         ovf,
    input logic         done
);
    a_r8_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r8_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));

    a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));

    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr |=> !ovf);

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    a_r4_inc_keeps_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[1] && !ovf_clr) |=> (ovf == $past(ovf)));

    a_r7_skip_only_isk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> ($past(start) && ($past(op) == 2'd3)));

    a_r6_wb_only_inc: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done && $past(op[1])));

    a_r1_add_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ($past(op) == 2'd0)) |-> (result != {W{1'b1}}));
endmodule

bind oc_arith_unit oc_arith_unit_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .ovf_clr  (ovf_clr),
    .result   (result),
    .wb_en    (wb_en),
    .skip_req (skip_req),
    .ovf      (ovf),
    .done     (done)
);

// File: tb/oc_arith_unit_tb_top.sv
`timescale 1ns/1ps
module oc_arith_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [17:0] acc_in = '0;
    logic [17:0] opnd_in = '0;
    logic        ovf_clr = 1'b0;
    logic [17:0] result;
    logic [17:0] wb_data;
    logic        wb_en;
    logic        skip_req;
    logic        ovf;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    oc_arith_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op),
        .acc_in   (acc_in),
        .opnd_in  (opnd_in),
        .ovf_clr  (ovf_clr),
        .result   (result),
        .wb_data  (wb_data),
        .wb_en    (wb_en),
        .skip_req (skip_req),
        .ovf      (ovf),
        .done     (done)
    );

    // {op, acc, opnd, expected result, expected skip, expected overflow}
    localparam int NV = 16;
    localparam logic [57:0] VEC [NV] = '{
        {2'd0, 18'h00005, 18'h00003, 18'h00008, 1'b0, 1'b0},
        {2'd0, 18'h00005, 18'h3FFFC, 18'h00002, 1'b0, 1'b0},
        {2'd0, 18'h00003, 18'h3FFFC, 18'h00000, 1'b0, 1'b0},
        {2'd0, 18'h1FFFF, 18'h00001, 18'h20000, 1'b0, 1'b1},
        {2'd0, 18'h3FFFF, 18'h3FFFF, 18'h00000, 1'b0, 1'b0},
        {2'd1, 18'h00007, 18'h00002, 18'h00005, 1'b0, 1'b0},
        {2'd1, 18'h3FFFF, 18'h00000, 18'h3FFFF, 1'b0, 1'b0},
        {2'd1, 18'h00002, 18'h00007, 18'h3FFFA, 1'b0, 1'b0},
        {2'd1, 18'h20000, 18'h00001, 18'h1FFFF, 1'b0, 1'b1},
        {2'd2, 18'h12345, 18'h00005, 18'h00006, 1'b0, 1'b0},
        {2'd2, 18'h00000, 18'h3FFFE, 18'h00000, 1'b0, 1'b0},
        {2'd2, 18'h00000, 18'h3FFFF, 18'h00001, 1'b0, 1'b0},
        {2'd3, 18'h00000, 18'h00005, 18'h00006, 1'b1, 1'b0},
        {2'd3, 18'h00000, 18'h3FFFC, 18'h3FFFD, 1'b0, 1'b0},
        {2'd3, 18'h1FFFF, 18'h1FFFF, 18'h20000, 1'b0, 1'b0},
        {2'd3, 18'h00000, 18'h3FFFE, 18'h00000, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // strobe one request; return half a cycle after the capturing edge
    task automatic run_op(input logic [1:0] o, input logic [17:0] a, input logic [17:0] b,
                          input logic clr);
        @(negedge clk);
        op      = o;
        acc_in  = a;
        opnd_in = b;
        start   = 1'b1;
        ovf_clr = clr;
        @(negedge clk);
        start   = 1'b0;
        ovf_clr = 1'b0;
    endtask

    task automatic clear_ovf();
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        string rq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9", result, 18'h0);
        check("R9", wb_data, 18'h0);
        check("R9", {17'd0, ovf}, 18'h0);
        check("R9", {17'd0, done}, 18'h0);
        check("R9", {17'd0, skip_req}, 18'h0);
        check("R9", {17'd0, wb_en}, 18'h0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  vo;
            logic [17:0] va, vb, vr;
            logic        vs, vv;
            {vo, va, vb, vr, vs, vv} = VEC[i];
            case (vo)
                2'd0: rq = "R1";
                2'd1: rq = "R2";
                2'd2: rq = "R6";
                default: rq = "R7";
            endcase
            clear_ovf();
            run_op(vo, va, vb, 1'b0);
            check(rq, result, vr);
            check("R3", {17'd0, ovf}, {17'd0, vv});
            check("R7", {17'd0, skip_req}, {17'd0, vs});
            check("R6", {17'd0, wb_en}, {17'd0, vo[1]});
            if (vo[1]) check("R6", wb_data, vr);
            check("R8", {17'd0, done}, 18'h1);
        end

        // R8: done is a single pulse and result holds afterwards
        run_op(2'd0, 18'h00010, 18'h00020, 1'b0);
        @(negedge clk);
        check("R8", {17'd0, done}, 18'h0);
        check("R8", result, 18'h00030);
        check("R7", {17'd0, skip_req}, 18'h0);

        // R4: overflow is sticky through clean add and through increments
        clear_ovf();
        run_op(2'd0, 18'h1FFFF, 18'h1FFFF, 1'b0);
        check("R3", {17'd0, ovf}, 18'h1);
        run_op(2'd0, 18'h00001, 18'h00001, 1'b0);
        check("R4", {17'd0, ovf}, 18'h1);
        check("R1", result, 18'h00002);
        run_op(2'd3, 18'h0, 18'h00001, 1'b0);
        check("R4", {17'd0, ovf}, 18'h1);

        // R4: increment forms never set overflow
        clear_ovf();
        run_op(2'd2, 18'h0, 18'h1FFFF, 1'b0);
        check("R4", {17'd0, ovf}, 18'h0);
        check("R6", result, 18'h20000);

        // R5: clear alone, and clear beating a simultaneous overflow
        run_op(2'd1, 18'h20000, 18'h00001, 1'b0);
        check("R3", {17'd0, ovf}, 18'h1);
        clear_ovf();
        check("R5", {17'd0, ovf}, 18'h0);
        run_op(2'd0, 18'h1FFFF, 18'h00001, 1'b1);
        check("R5", {17'd0, ovf}, 18'h0);
        check("R1", result, 18'h20000);

        // R2 vs R1: negative-zero asymmetry on the same operands
        run_op(2'd0, 18'h3FFFF, 18'h00000, 1'b0);
        check("R1", result, 18'h00000);
        run_op(2'd1, 18'h3FFFF, 18'h00000, 1'b0);
        check("R2", result, 18'h3FFFF);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule